// File: doc/BRIEF.md
# Serial Signed Fixed-Point Multiplier

This block multiplies two signed two's-complement fixed-point numbers in a Q format. Both the total width and the number of fractional bits are set by parameters. The default is 32 bits with 16 fractional bits.

The product is built one multiplier bit per clock by shift-and-add on the operand magnitudes. No hard multiplier is inferred, and the logic path per cycle stays one adder long. After the iteration, the block puts the sign back. It rescales the double-width product by the fractional width, truncating the magnitude toward zero. It then range-checks the value against the output width and saturates it when the value does not fit.

A client drives operands together with `start` while `ready` is high. The result and an overflow flag appear alongside a one-cycle `valid` pulse, a fixed number of cycles later. The next operation may be requested in the same cycle that `valid` is high.

Top module: `fxp_serial_mul`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block goes to `ready`=1, `valid`=0, `result`=0 and `ovf`=0.
- R2: An operation is accepted at a rising edge where `start` and `ready` are both 1. `ready` is 0 from the next cycle up to, but not including, the cycle in which `valid` is 1.
- R3: `valid` is 1 for exactly one cycle. It rises TOTAL_W+2 rising edges after the accepting edge.
- R4: `start` has no effect while `ready` is 0. The running operation completes with its original operands and its original timing.
- R5: For in-range products, `result` is sign(a·b)·floor(|a·b| / 2^FRAC_W), in the raw integer view of the operands. The magnitude is truncated toward zero, and `ovf` is 0.
- R6: When that value exceeds 2^(TOTAL_W-1)-1, `result` is the most positive code (0 followed by ones) and `ovf` is 1.
- R7: When that value is below -2^(TOTAL_W-1), `result` is the most negative code (1 followed by zeros) and `ovf` is 1. A value equal to -2^(TOTAL_W-1) is returned without overflow.
- R8: `result` and `ovf` keep their values in every cycle in which `valid` is 0.
- R9: A `start` presented in the cycle where `valid` is 1 is accepted at the next edge. Operations can therefore run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to multiply `op_a` by `op_b` |
| op_a | input | TOTAL_W | Multiplicand, signed Q format |
| op_b | input | TOTAL_W | Multiplier, signed Q format |
| ready | output | 1 | Idle and able to accept `start` |
| valid | output | 1 | One-cycle pulse marking a new result |
| result | output | TOTAL_W | Rescaled, saturated product |
| ovf | output | 1 | Product was outside the representable range |

## Verification
The bench builds the block at its default 32-bit width with 16 fractional bits. At that width a 64-bit integer reference holds every exact product. Both extremes of the range can be reached:
- the most negative operand multiplied by itself and by minus one;
- the exact lower bound, reached without overflow;
- tiny negative products that expose truncation toward zero rather than toward minus infinity.

The full 32-iteration latency is exercised, which gives a long busy window in which stray requests can be injected.

// File: rtl/fxp_mul_pkg.sv
package fxp_mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ITER  = 2'd1,
    ST_SCALE = 2'd2,
    ST_PACK  = 2'd3
  } mul_state_e;

endpackage

// File: rtl/fxp_mul_ctrl.sv
module fxp_mul_ctrl #(
  parameter int TOTAL_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic accept,
  output logic iter_en,
  output logic scale_en,
  output logic pack_en
);
  import fxp_mul_pkg::*;

  localparam int CNT_W = (TOTAL_W > 1) ? $clog2(TOTAL_W) : 1;
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(TOTAL_W - 1);

  mul_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;

  assign ready    = ready_q;
  assign accept   = start && ready_q && (state_q == ST_IDLE);
  assign iter_en  = (state_q == ST_ITER);
  assign scale_en = (state_q == ST_SCALE);
  assign pack_en  = (state_q == ST_PACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_ITER;
            cnt_q   <= '0;
            ready_q <= 1'b0;
          end
        end
        ST_ITER: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_ITER) state_q <= ST_SCALE;
        end
        ST_SCALE: state_q <= ST_PACK;
        ST_PACK: begin
          state_q <= ST_IDLE;
          ready_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> !ready); // R2
  AST_READY_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(start)); // R2
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!ready && state_q == ST_IDLE) |-> 1'b0); // R4

endmodule

// File: rtl/fxp_mul_accum.sv
module fxp_mul_accum #(
  parameter int TOTAL_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic                 iter_en,
  input  logic [TOTAL_W-1:0]   op_a,
  input  logic [TOTAL_W-1:0]   op_b,
  output logic [2*TOTAL_W-1:0] prod_mag,
  output logic                 prod_neg
);
  localparam int PW = 2 * TOTAL_W;

  logic [TOTAL_W-1:0] mag_a, mag_b;
  logic [PW-1:0]      mcand_q;
  logic [TOTAL_W-1:0] mplier_q;
  logic [PW-1:0]      acc_q;
  logic               neg_q;

  assign mag_a = op_a[TOTAL_W-1] ? (~op_a + 1'b1) : op_a;
  assign mag_b = op_b[TOTAL_W-1] ? (~op_b + 1'b1) : op_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      neg_q    <= 1'b0;
    end else if (accept) begin
      mcand_q  <= {{TOTAL_W{1'b0}}, mag_a};
      mplier_q <= mag_b;
      acc_q    <= '0;
      neg_q    <= op_a[TOTAL_W-1] ^ op_b[TOTAL_W-1];
    end else if (iter_en) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign prod_mag = acc_q;
  assign prod_neg = neg_q;

endmodule

// File: rtl/fxp_mul_pack.sv
module fxp_mul_pack #(
  parameter int TOTAL_W = 32,
  parameter int FRAC_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scale_en,
  input  logic                 pack_en,
  input  logic [2*TOTAL_W-1:0] prod_mag,
  input  logic                 prod_neg,
  output logic                 valid,
  output logic [TOTAL_W-1:0]   result,
  output logic                 ovf
);
  localparam int PW = 2 * TOTAL_W;
  localparam logic [TOTAL_W-1:0] MAX_CODE = {1'b0, {(TOTAL_W-1){1'b1}}};
  localparam logic [TOTAL_W-1:0] MIN_CODE = {1'b1, {(TOTAL_W-1){1'b0}}};

  logic [PW-1:0]      shifted;
  logic [PW-1:0]      scaled_q;
  logic [PW-TOTAL_W:0] top_bits;
  logic               out_of_range;
  logic               valid_q, ovf_q;
  logic [TOTAL_W-1:0] result_q;

  assign shifted = prod_mag >> FRAC_W;

  always_ff @(posedge clk) begin
    if (rst) scaled_q <= '0;
    else if (scale_en) scaled_q <= prod_neg ? (~shifted + 1'b1) : shifted;
  end

  assign top_bits     = scaled_q[PW-1:TOTAL_W-1];
  assign out_of_range = !((&top_bits) || !(|top_bits));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      valid_q <= pack_en;
      if (pack_en) begin
        ovf_q    <= out_of_range;
        result_q <= out_of_range ? (scaled_q[PW-1] ? MIN_CODE : MAX_CODE)
                                 : scaled_q[TOTAL_W-1:0];
      end
    end
  end

  assign valid  = valid_q;
  assign result = result_q;
  assign ovf    = ovf_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(result) && $stable(ovf))); // R8
  AST_OVF_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (valid && ovf) |-> (result == MAX_CODE || result == MIN_CODE)); // R6

endmodule

// File: rtl/fxp_serial_mul.sv
module fxp_serial_mul #(
  parameter int TOTAL_W = 32,
  parameter int FRAC_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [TOTAL_W-1:0] op_a,
  input  logic [TOTAL_W-1:0] op_b,
  output logic               ready,
  output logic               valid,
  output logic [TOTAL_W-1:0] result,
  output logic               ovf
);
  localparam int PW = 2 * TOTAL_W;

  logic          accept, iter_en, scale_en, pack_en;
  logic [PW-1:0] prod_mag;
  logic          prod_neg;

  fxp_mul_ctrl #(.TOTAL_W(TOTAL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ready(ready),
    .accept(accept), .iter_en(iter_en), .scale_en(scale_en), .pack_en(pack_en)
  );

  fxp_mul_accum #(.TOTAL_W(TOTAL_W)) u_accum (
    .clk(clk), .rst(rst), .accept(accept), .iter_en(iter_en),
    .op_a(op_a), .op_b(op_b), .prod_mag(prod_mag), .prod_neg(prod_neg)
  );

  fxp_mul_pack #(.TOTAL_W(TOTAL_W), .FRAC_W(FRAC_W)) u_pack (
    .clk(clk), .rst(rst), .scale_en(scale_en), .pack_en(pack_en),
    .prod_mag(prod_mag), .prod_neg(prod_neg),
    .valid(valid), .result(result), .ovf(ovf)
  );

  AST_VALID_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    valid |-> ready); // R2
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (valid && start) |=> !ready); // R9

endmodule

// File: tb/test_fxp_serial_mul.sv
module test_fxp_serial_mul;
  localparam int TW = 32;
  localparam int FW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = TW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [TW-1:0] op_a = '0, op_b = '0;
  logic          ready, valid, ovf;
  logic [TW-1:0] result;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R5";

  // reference model state
  bit            m_busy = 0;
  int            m_cnt = 0;
  bit            m_valid = 0;
  logic [TW-1:0] m_res = '0, m_pend_res = '0;
  bit            m_ovf = 0, m_pend_ovf = 0;
  bit            m_live = 0;

  fxp_serial_mul #(.TOTAL_W(TW), .FRAC_W(FW)) i_fxp_serial_mul (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .ready(ready), .valid(valid), .result(result), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void ref_mul(input logic [TW-1:0] a, input logic [TW-1:0] b,
                                  output logic [TW-1:0] r, output bit o);
    longint p, m, s;
    p = longint'($signed(a)) * longint'($signed(b));
    m = (p < 0) ? -p : p;
    s = m >> FW;
    if (p < 0) s = -s;
    if (s > 64'sd2147483647) begin r = 32'h7fffffff; o = 1; end
    else if (s < -64'sd2147483648) begin r = 32'h80000000; o = 1; end
    else begin r = s[TW-1:0]; o = 0; end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_valid = 0; m_res = '0; m_ovf = 0;
    end else begin
      m_valid = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_valid = 1; m_res = m_pend_res; m_ovf = m_pend_ovf; m_busy = 0;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        ref_mul(op_a, op_b, m_pend_res, m_pend_ovf);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (m_live && !rst) begin
      check(ready == !m_busy, "R2", "ready", TW'(ready), TW'(!m_busy));
      check(valid == m_valid, "R3", "valid", TW'(valid), TW'(m_valid));
      check(result == m_res, m_valid ? phase : "R8", "result", result, m_res);
      check(ovf == m_ovf, m_valid ? phase : "R8", "ovf", TW'(ovf), TW'(m_ovf));
    end
  end

  task automatic issue(input logic [TW-1:0] a, input logic [TW-1:0] b);
    while (!ready) @(negedge clk);
    start = 1; op_a = a; op_b = b;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input string tag, input logic [TW-1:0] a, input logic [TW-1:0] b);
    phase = tag;
    issue(a, b);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ready == 1'b1, "R1", "ready", TW'(ready), TW'(1));
    check(valid == 1'b0, "R1", "valid", TW'(valid), TW'(0));
    check(result == '0, "R1", "result", result, '0);
    check(ovf == 1'b0, "R1", "ovf", TW'(ovf), TW'(0));
    rst = 0;
    m_live = 1;
    @(negedge clk);

    // R5: in-range products and truncation toward zero
    run_op("R5", 32'h0001_8000, 32'h0002_0000);
    run_op("R5", 32'hFFFE_8000, 32'h0002_4000);
    run_op("R5", 32'hFFFF_FFFF, 32'h0000_0001);
    run_op("R5", 32'hFFFF_FFFD, 32'h0000_8000);
    run_op("R5", 32'h0000_0000, 32'h8000_0000);
    run_op("R5", 32'h7FFF_FFFF, 32'h0001_0000);

    // R6: positive overflow saturates high
    run_op("R6", 32'h012C_0000, 32'h012C_0000);
    run_op("R6", 32'h8000_0000, 32'h8000_0000);
    run_op("R6", 32'h8000_0000, 32'hFFFF_0000);
    run_op("R6", 32'h7FFF_FFFF, 32'h7FFF_FFFF);

    // R7: negative overflow saturates low; exact bound is not overflow
    run_op("R7", 32'h012C_0000, 32'hFED4_0000);
    run_op("R7", 32'h7FFF_FFFF, 32'h8000_0000);
    run_op("R7", 32'h8000_0000, 32'h0001_0000);

    // R4: start pulses while busy are ignored
    phase = "R4";
    issue(32'h0003_0000, 32'h0005_0000);
    repeat (5) @(negedge clk);
    start = 1; op_a = 32'h7FFF_FFFF; op_b = 32'h7FFF_FFFF;
    repeat (10) @(negedge clk);
    start = 0; op_a = '0; op_b = '0;
    wait_done();

    // R9: back-to-back issue in the valid cycle
    phase = "R9";
    issue(32'h0002_0000, 32'h0002_0000);
    for (int k = 0; k < 4; k++) begin
      while (!valid) @(negedge clk);
      start = 1; op_a = 32'(k + 1) << 16; op_b = 32'hFFFF_8000;
      @(negedge clk);
      start = 0;
    end
    wait_done();

    // R5: mixed-magnitude pseudo-random operands
    for (int k = 0; k < 40; k++) begin
      logic [TW-1:0] a, b;
      a = $urandom;
      b = $urandom;
      if (k % 3 == 0) a = {{12{a[19]}}, a[19:0]};
      if (k % 4 == 1) b = {{14{b[17]}}, b[17:0]};
      run_op((k % 2) ? "R5" : "R6", a, b);
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired after %0d cycles", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule